// File: doc/BRIEF.md
# Multi-Channel Triggered Pulse Generator

This block produces up to five independent pulse trains from one shared clock prescaler. Each channel holds three 16-bit settings counted in prescaled ticks: an initial delay, an on-time and a period. After the start event, a channel first waits out its delay. It then drives its output high for the on-time at the beginning of every period, and repeats this every period.

A start happens either right after the core is enabled or on a rising edge of an external trigger input. The core then runs either without end or for a programmed number of ticks. At the end of a fixed run it stops all outputs and sets a sticky completion flag. That flag can drive a level interrupt. Software configures the block over a small word-addressed register bus. Writes take effect on the clock edge. Reads are combinational from the address.

Top module: `pulse_sequencer`

## Requirements
- R1: After reset, all pulse outputs and the interrupt are low. Word 0 reads the VERSION parameter and word 1 reads zero.
- R2: Register map (word addresses):
  - Word 1 is control/status: bit0 core enable, bit1 continuous, bit2 external trigger, bit3 interrupt enable, bit4 completion flag, bits[11:8] divisor field.
  - Word 2 is the run duration.
  - For channel n, word 3+3n is the delay, word 4+3n holds on-time in bits[15:0] and channel enable in bit16, and word 5+3n is the period.
  - Every writable field reads back what was written.
- R3: One prescaled tick lasts 18 plus the divisor field clock cycles, giving 18 to 33.
- R4: A start at clock edge E0 is followed, after edge E0+m, by tick index k = floor(m/div). The output is high when k is at least the delay and (k-delay) mod period is below the on-time.
- R5: An on-time equal to or greater than the period holds the output high after the delay. A period of 0 keeps the output low.
- R6: A channel with its enable bit clear stays low. Clearing the core enable forces every output low by the second clock edge after the write.
- R7: In immediate mode, the run starts on the clock edge after the edge that writes the core enable.
- R8: In external-trigger mode, the run starts on the clock edge at which the trigger is high after having been low. A trigger already high when the core is enabled does not start it.
- R9: In continuous mode the run never ends and the completion flag is never set.
- R10: In fixed mode with duration D, tick D+1 sets the completion flag, drives all outputs low and stops the run until the core enable is cleared. D=0 ends the run on the first tick.
- R11: The completion flag stays set until word 1 is written with bit4 = 1. If the flag is set on the same edge as that clear, setting takes priority. The interrupt output equals flag AND interrupt enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| trig_in | input | 1 | External start trigger, synchronous to clk |
| pulse_out | output | 5 | Pulse channel outputs |
| irq | output | 1 | Completion interrupt level |

## Verification
The run starts one edge after the enabling write, or on the edge that first sees a high trigger. The bench samples at the falling edge just after that start edge and counts m from there. Each output sample is compared against floor(m/div) evaluated with the delay, on-time and period rule.

The completion flag and interrupt are due exactly div*(D+1) edges after start. The bench therefore walks every sample of the window, including the one just before and the one just after completion.

Disabling is checked two falling edges after the write. Flag clearing and read-back are checked at the falling edge after the write edge.

// File: rtl/pulse_sequencer.sv
module pulse_sequencer #(
  parameter int NUM_CH  = 5,
  parameter int CW      = 16,
  parameter int DUR_W   = 16,
  parameter int DIV_MIN = 18,
  parameter int DIV_FW  = 4,
  parameter logic [31:0] VERSION = 32'h0001_0003,
  localparam int NWORDS = 3 + 3*NUM_CH,
  localparam int AW     = $clog2(NWORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [AW-1:0]     bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              trig_in,
  output logic [NUM_CH-1:0] pulse_out,
  output logic              irq
);
  localparam int PW = $clog2(DIV_MIN + (1 << DIV_FW));

  logic              ctl_en, ctl_cont, ctl_ext, ctl_ie, done_flag;
  logic [DIV_FW-1:0] div_f;
  logic [DUR_W-1:0]  dur_reg, dcount;
  logic              running, stopped, trig_q;
  logic [PW-1:0]     pcnt, div_last;

  logic [CW-1:0] dly_r [NUM_CH];
  logic [CW-1:0] on_r  [NUM_CH];
  logic [CW-1:0] per_r [NUM_CH];
  logic [CW-1:0] dcnt  [NUM_CH];
  logic [CW-1:0] pos   [NUM_CH];
  logic [NUM_CH-1:0] ch_en, in_per;

  logic wr_ctrl, clr_req, tick, start, finish, adv;

  assign wr_ctrl  = bus_wr && (bus_addr == AW'(1));
  assign clr_req  = wr_ctrl && bus_wdata[4];
  assign div_last = PW'(DIV_MIN - 1) + PW'(div_f);
  assign tick     = running && (pcnt >= div_last);
  assign start    = ctl_en && !running && !stopped && (!ctl_ext || (trig_in && !trig_q));
  assign finish   = tick && !ctl_cont && (dcount == dur_reg);
  assign adv      = tick && !finish;
  assign irq      = done_flag && ctl_ie;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {ctl_en, ctl_cont, ctl_ext, ctl_ie, done_flag} <= '0;
      div_f   <= '0;
      dur_reg <= '0;
      dcount  <= '0;
      running <= 1'b0;
      stopped <= 1'b0;
      trig_q  <= 1'b0;
      pcnt    <= '0;
    end else begin
      trig_q <= trig_in;
      if (wr_ctrl) begin
        ctl_en   <= bus_wdata[0];
        ctl_cont <= bus_wdata[1];
        ctl_ext  <= bus_wdata[2];
        ctl_ie   <= bus_wdata[3];
        div_f    <= bus_wdata[8 +: DIV_FW];
      end
      if (finish)       done_flag <= 1'b1;
      else if (clr_req) done_flag <= 1'b0;
      if (bus_wr && bus_addr == AW'(2)) dur_reg <= bus_wdata[DUR_W-1:0];

      if (!ctl_en) begin
        running <= 1'b0;
        stopped <= 1'b0;
      end else if (start) begin
        running <= 1'b1;
        pcnt    <= '0;
        dcount  <= '0;
      end else if (running) begin
        pcnt <= tick ? '0 : pcnt + 1'b1;
        if (finish) begin
          running <= 1'b0;
          stopped <= 1'b1;
        end else if (tick && !ctl_cont) begin
          dcount <= dcount + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_CH; i++) begin
        dly_r[i] <= '0;
        on_r[i]  <= '0;
        per_r[i] <= '0;
        dcnt[i]  <= '0;
        pos[i]   <= '0;
      end
      ch_en  <= '0;
      in_per <= '0;
    end else begin
      for (int i = 0; i < NUM_CH; i++) begin
        if (bus_wr && bus_addr == AW'(3 + 3*i)) dly_r[i] <= bus_wdata[CW-1:0];
        if (bus_wr && bus_addr == AW'(4 + 3*i)) begin
          on_r[i]  <= bus_wdata[CW-1:0];
          ch_en[i] <= bus_wdata[16];
        end
        if (bus_wr && bus_addr == AW'(5 + 3*i)) per_r[i] <= bus_wdata[CW-1:0];

        if (start) begin
          in_per[i] <= (dly_r[i] == '0);
          dcnt[i]   <= '0;
          pos[i]    <= '0;
        end else if (adv) begin
          if (!in_per[i]) begin
            if (({1'b0, dcnt[i]} + 1'b1) >= {1'b0, dly_r[i]}) begin
              in_per[i] <= 1'b1;
              pos[i]    <= '0;
            end else begin
              dcnt[i] <= dcnt[i] + 1'b1;
            end
          end else begin
            pos[i] <= (({1'b0, pos[i]} + 1'b1) >= {1'b0, per_r[i]}) ? '0 : pos[i] + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CH; i++)
      pulse_out[i] = running && ch_en[i] && in_per[i] && (per_r[i] != '0) && (pos[i] < on_r[i]);
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      AW'(0): bus_rdata = VERSION;
      AW'(1): begin
        bus_rdata[0] = ctl_en;
        bus_rdata[1] = ctl_cont;
        bus_rdata[2] = ctl_ext;
        bus_rdata[3] = ctl_ie;
        bus_rdata[4] = done_flag;
        bus_rdata[8 +: DIV_FW] = div_f;
      end
      AW'(2): bus_rdata[DUR_W-1:0] = dur_reg;
      default: ;
    endcase
    for (int i = 0; i < NUM_CH; i++) begin
      if (bus_addr == AW'(3 + 3*i)) bus_rdata[CW-1:0] = dly_r[i];
      if (bus_addr == AW'(4 + 3*i)) begin
        bus_rdata[CW-1:0] = on_r[i];
        bus_rdata[16]     = ch_en[i];
      end
      if (bus_addr == AW'(5 + 3*i)) bus_rdata[CW-1:0] = per_r[i];
    end
  end

  AST_PRESCALE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running && $past(running) && $stable(div_f) |-> pcnt <= div_last); // R3
  AST_DISABLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_en |=> pulse_out == '0); // R6
  AST_IMMEDIATE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ctl_en) && !$past(ctl_ext) && !$past(running) && !$past(stopped) |-> running); // R7
  AST_TRIG_EDGE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(running) && $past(ctl_ext) |-> $past(trig_in) && !$past(trig_q)); // R8
  AST_CONT_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(running) && $past(ctl_cont) |-> !$rose(done_flag)); // R9
  AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_flag) |-> pulse_out == '0); // R10
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    $past(done_flag) && !$past(clr_req) |-> done_flag); // R11
endmodule

// File: tb/sim_pulse_sequencer.sv
module sim_pulse_sequencer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        trig_in = 1'b0;
  logic [4:0]  pulse_out;
  logic        irq;

  int checks = 0;
  int failures = 0;

  localparam logic [31:0] VER = 32'h0001_0003;

  pulse_sequencer u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .trig_in(trig_in),
    .pulse_out(pulse_out), .irq(irq)
  );

  always #4 clk = ~clk;

  // {div field[4], delay[16], on[16], period[16], duration[16], continuous[1]}
  localparam int NV = 6;
  localparam logic [68:0] VEC [NV] = '{
    {4'd0,  16'd2, 16'd3, 16'd5, 16'd0, 1'b1},
    {4'd15, 16'd0, 16'd1, 16'd4, 16'd0, 1'b1},
    {4'd7,  16'd1, 16'd5, 16'd5, 16'd0, 1'b1},
    {4'd0,  16'd1, 16'd2, 16'd0, 16'd0, 1'b1},
    {4'd3,  16'd3, 16'd2, 16'd3, 16'd6, 1'b0},
    {4'd0,  16'd0, 16'd1, 16'd2, 16'd0, 1'b0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = 5'(a); bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    bus_addr = 5'(a);
    #1;
    d = bus_rdata;
  endtask

  function automatic logic model(int m, int dv, int d, int on, int per, int dur, bit cont);
    int k;
    k = m / dv;
    if (!cont && k > dur) return 1'b0;
    if (k < d || per == 0) return 1'b0;
    return ((k - d) % per) < on;
  endfunction

  function automatic logic [31:0] ctrl(bit en, bit cont, bit ext, bit ie, bit clr, int f);
    return {20'd0, 4'(f), 3'd0, clr, ie, ext, cont, en};
  endfunction

  initial begin
    #(8 * 200000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(pulse_out == 0, "R1 outputs low", 32'(pulse_out), 0);
    chk(irq == 0, "R1 irq low", 32'(irq), 0);
    rd(0, r); chk(r == VER, "R1 version word", r, VER);
    rd(1, r); chk(r == 0, "R1 control word", r, 0);
    rst_n = 1'b1;

    // R2 read-back
    wr(15, 32'h0000_ABCD);
    rd(15, r); chk(r == 32'h0000_ABCD, "R2 ch4 delay", r, 32'h0000_ABCD);
    wr(16, 32'h0001_1234);
    rd(16, r); chk(r == 32'h0001_1234, "R2 ch4 ctrl", r, 32'h0001_1234);
    wr(11, 32'h0000_0777);
    rd(11, r); chk(r == 32'h0000_0777, "R2 ch2 period", r, 32'h0000_0777);
    wr(2, 32'h0000_0042);
    rd(2, r); chk(r == 32'h0000_0042, "R2 duration", r, 32'h0000_0042);

    // R3 R4 R5 R6 R9 R10 table walk
    for (int v = 0; v < NV; v++) begin
      int f, d, on, per, dur, dv, win, bad, first_m;
      bit cont;
      f = VEC[v][68:65]; d = VEC[v][64:49]; on = VEC[v][48:33];
      per = VEC[v][32:17]; dur = VEC[v][16:1]; cont = VEC[v][0];
      dv = 18 + f;
      win = cont ? dv * 12 : dv * (dur + 3);
      wr(1, ctrl(0, 0, 0, 0, 1, 0));
      wr(3, 32'(d)); wr(4, 32'h0001_0000 | 32'(on)); wr(5, 32'(per));
      wr(6, 0); wr(7, 32'h0000_0001); wr(8, 2);
      wr(2, 32'(dur));
      wr(1, ctrl(1, cont, 0, 1, 0, f));
      bad = 0; first_m = -1;
      for (int m = 0; m < win; m++) begin
        logic e;
        @(negedge clk);
        e = model(m, dv, d, on, per, dur, cont);
        if (pulse_out[0] !== e) begin
          bad++;
          if (first_m < 0) first_m = m;
        end
        if (pulse_out[1] !== 1'b0) bad++;
      end
      chk(bad == 0, $sformatf("R4 R5 R6 vector %0d waveform first_bad_m=%0d", v, first_m), 32'(bad), 0);
      chk(irq == !cont, $sformatf("R9 R10 vector %0d irq", v), 32'(irq), 32'(!cont));
      rd(1, r);
      chk(r[4] == !cont, $sformatf("R10 vector %0d flag", v), 32'(r[4]), 32'(!cont));
      if (!cont) chk(pulse_out == 0, $sformatf("R10 vector %0d stopped", v), 32'(pulse_out), 0);
    end

    // R11 flag sticky, irq gating, write-one-to-clear
    wr(1, ctrl(1, 0, 0, 0, 0, 0));
    chk(irq == 0, "R11 irq masked", 32'(irq), 0);
    rd(1, r); chk(r[4] == 1, "R11 flag sticky", 32'(r[4]), 1);
    wr(1, ctrl(1, 0, 0, 1, 1, 0));
    rd(1, r); chk(r[4] == 0, "R11 flag cleared", 32'(r[4]), 0);
    chk(irq == 0, "R11 irq after clear", 32'(irq), 0);

    // R7 immediate start timing
    wr(1, ctrl(0, 0, 0, 0, 0, 0));
    wr(3, 0); wr(4, 32'h0001_0001); wr(5, 2);
    wr(1, ctrl(1, 1, 0, 0, 0, 0));
    chk(pulse_out[0] == 0, "R7 not before start edge", 32'(pulse_out[0]), 0);
    @(negedge clk);
    chk(pulse_out[0] == 1, "R7 high after start edge", 32'(pulse_out[0]), 1);

    // R6 global disable
    wr(1, ctrl(0, 1, 0, 0, 0, 0));
    @(negedge clk);
    chk(pulse_out == 0, "R6 disable forces low", 32'(pulse_out), 0);

    // R8 external trigger
    trig_in = 1'b1;
    wr(1, ctrl(1, 1, 1, 0, 0, 0));
    repeat (60) @(negedge clk);
    chk(pulse_out[0] == 0, "R8 held-high trigger ignored", 32'(pulse_out[0]), 0);
    trig_in = 1'b0;
    repeat (5) @(negedge clk);
    chk(pulse_out[0] == 0, "R8 idle before edge", 32'(pulse_out[0]), 0);
    trig_in = 1'b1;
    @(negedge clk);
    chk(pulse_out[0] == 1, "R8 start on rising edge", 32'(pulse_out[0]), 1);
    repeat (18) @(negedge clk);
    chk(pulse_out[0] == 0, "R8 R3 low at second tick", 32'(pulse_out[0]), 0);
    trig_in = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule